// File: doc/BRIEF.md
# Shared-Bus Arbitration Sequencer

This block is the contention front end of one device on a shared parallel peripheral bus. The bus has wired-OR busy, select and reset lines and an 8-bit line group that carries device IDs during contention. The block watches the busy and select lines until they have stayed idle long enough to count as a free bus. When the host has a request pending, it then drives busy together with the one-hot bit of its own ID. It waits out the minimum contention interval, waits for the ID lines to stop moving, and compares the IDs it sees. If no higher ID is present it takes the bus by driving select. Otherwise it withdraws and waits for the next free bus.

Every bus input passes through a synchroniser chain before it is used. A foreign select seen during contention, or the bus reset line, makes the block drop everything it drives within a few cycles. All timing windows are given in nanoseconds and converted to clock cycles from the `CLK_HZ` parameter. A holder of the bus gives it back by pulsing `release_req`.

Top module: `bus_arb_seq`

## Requirements
- R1: After the synchronous reset `rst`, `bsy_drive`, `sel_drive`, `won_pulse` are low and `id_drive` is all zero.
- R2: The bus counts as free only after the synchronised busy and select lines have both been low for SETTLE_CYC consecutive cycles. Any high cycle on either line restarts that count from zero.
- R3: With `arb_req` high and the block idle, `bsy_drive` and `id_drive` = 1 << `own_id` rise together exactly SYNC_STAGES + SETTLE_CYC + 1 clock edges after both bus lines fall. That is one cycle after the free decision, which lies inside both the free-to-busy and free-to-ID maximum windows.
- R4: With `arb_req` low, a free bus causes no drive at all.
- R5: The contention outcome is decided no earlier than ARB_CYC + 1 edges after `bsy_drive` rises, and exactly then when the ID lines are already settled.
- R6: The outcome is decided only once the synchronised ID lines have been unchanged for DESKEW_CYC cycles. A change seen on the lines in the cycle after edge k moves the decision to edge k + SYNC_STAGES + 2 + DESKEW_CYC.
- R7: Priority follows bit index on the ID lines, and bit 7 is highest. The block wins if and only if no bit above `own_id` is set. Lower bits have no effect on the outcome.
- R8: On a win, `sel_drive` rises with a `won_pulse` that lasts exactly one cycle. Busy, select and the ID bit then stay driven.
- R9: On a loss, `bsy_drive` and `id_drive` fall at the decision edge, with no `won_pulse`. The block then contends again at the next free bus if `arb_req` is still high.
- R10: A select line driven by another device during contention releases all drives SYNC_STAGES + 1 edges after it appears.
- R11: The bus reset line releases all drives SYNC_STAGES + 1 edges after it rises, from any state, and keeps them released while it stays high. The block may contend again SYNC_STAGES + 1 edges after the line falls, provided the bus is free.
- R12: While the bus is held, `release_req` drops busy, select and the ID bit at the next edge.
- R13: Each nanosecond window is converted to cycles at `CLK_HZ`, with minimums rounded up and maximums rounded down. At 250 MHz the 45 ns stabilisation wait is 12 cycles and the 2.4 µs contention wait is 600 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_req | input | 1 | Host wants the bus |
| own_id | input | $clog2(DATA_W) | This device's ID (bit index), captured when contention starts |
| release_req | input | 1 | Give the held bus back |
| bsy_line | input | 1 | Busy line level (wired-OR, asynchronous) |
| sel_line | input | 1 | Select line level (wired-OR, asynchronous) |
| rst_line | input | 1 | Bus reset line level (asynchronous) |
| data_line | input | DATA_W | ID/data line levels (wired-OR, asynchronous) |
| bsy_drive | output | 1 | Drive busy |
| sel_drive | output | 1 | Drive select |
| id_drive | output | DATA_W | One-hot own-ID drive onto the ID lines |
| won_pulse | output | 1 | One-cycle pulse on winning |

## Verification
The state of the block shows directly in its registered drives, so a wrong decision appears at the ports on the very edge it is taken. A wrong state might be a premature free detection, a stale deskew count or a reversed priority mask. The result is a busy drive that rises off the expected edge, a decision that moves away from ARB_CYC + 1, or a won/lost outcome that disagrees with the bit comparison. The bench sweeps every pairing of own ID and competitor ID, which covers each priority mask. Release paths are timed to the exact edge, so a missing synchroniser stage or an extra one shifts the observed cycle by one.

// File: rtl/bus_arb_pkg.sv
`timescale 1ns/1ps
package bus_arb_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE    = 2'd0,
    ARB_CONTEND = 2'd1,
    ARB_OWNED   = 2'd2
  } arb_state_e;

  // Minimum window: round the cycle count up.
  function automatic int ns_to_cyc_min(input int unsigned ns, input longint unsigned hz);
    longint unsigned prod;
    prod = 64'(ns) * hz;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  // Maximum window: round the cycle count down.
  function automatic int ns_to_cyc_max(input int unsigned ns, input longint unsigned hz);
    longint unsigned prod;
    prod = 64'(ns) * hz;
    return int'(prod / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/bus_arb_sync.sv
`timescale 1ns/1ps
module bus_arb_sync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/bus_arb_free.sv
`timescale 1ns/1ps
module bus_arb_free #(
  parameter int SETTLE_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic bsy_s,
  input  logic sel_s,
  output logic free
);

  localparam int CW = $clog2(SETTLE_CYC + 2);

  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst)                          idle_cnt <= '0;
    else if (bsy_s || sel_s)          idle_cnt <= '0;
    else if (idle_cnt != CW'(SETTLE_CYC)) idle_cnt <= idle_cnt + 1'b1;
  end

  assign free = (idle_cnt == CW'(SETTLE_CYC));

endmodule

// File: rtl/bus_arb_deskew.sv
`timescale 1ns/1ps
module bus_arb_deskew #(
  parameter int DATA_W     = 8,
  parameter int DESKEW_CYC = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_s,
  output logic              stable
);

  localparam int CW = $clog2(DESKEW_CYC + 2);

  logic [DATA_W-1:0] data_prev;
  logic [CW-1:0]     calm_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_prev <= '0;
      calm_cnt  <= '0;
    end else begin
      data_prev <= data_s;
      if (data_s != data_prev)                calm_cnt <= '0;
      else if (calm_cnt != CW'(DESKEW_CYC))   calm_cnt <= calm_cnt + 1'b1;
    end
  end

  assign stable = (calm_cnt == CW'(DESKEW_CYC));

endmodule

// File: rtl/bus_arb_seq.sv
`timescale 1ns/1ps
module bus_arb_seq
  import bus_arb_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 250_000_000,
  parameter int              DATA_W       = 8,
  parameter int              SYNC_STAGES  = 2,
  parameter int unsigned     SETTLE_NS    = 400,
  parameter int unsigned     FREE_MAX_NS  = 800,
  parameter int unsigned     SET_MAX_NS   = 1800,
  parameter int unsigned     ARB_NS       = 2400,
  parameter int unsigned     CLEAR_MAX_NS = 800,
  parameter int unsigned     DESKEW_NS    = 45
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      arb_req,
  input  logic [$clog2(DATA_W)-1:0] own_id,
  input  logic                      release_req,
  input  logic                      bsy_line,
  input  logic                      sel_line,
  input  logic                      rst_line,
  input  logic [DATA_W-1:0]         data_line,
  output logic                      bsy_drive,
  output logic                      sel_drive,
  output logic [DATA_W-1:0]         id_drive,
  output logic                      won_pulse
);

  localparam int ID_W          = $clog2(DATA_W);
  localparam int SETTLE_CYC    = ns_to_cyc_min(SETTLE_NS, CLK_HZ);
  localparam int ARB_CYC       = ns_to_cyc_min(ARB_NS, CLK_HZ);
  localparam int DESKEW_CYC    = ns_to_cyc_min(DESKEW_NS, CLK_HZ);
  localparam int FREE_MAX_CYC  = ns_to_cyc_max(FREE_MAX_NS, CLK_HZ);
  localparam int SET_MAX_CYC   = ns_to_cyc_max(SET_MAX_NS, CLK_HZ);
  localparam int CLEAR_MAX_CYC = ns_to_cyc_max(CLEAR_MAX_NS, CLK_HZ);
  localparam int ARB_W         = $clog2(ARB_CYC + 2);
  localparam int SYNC_W        = DATA_W + 3;

  // The fixed latencies of this design must fit inside the maximum windows.
  if (SETTLE_CYC < 1 || ARB_CYC < 1 || FREE_MAX_CYC < 1 || SET_MAX_CYC < 1 ||
      CLEAR_MAX_CYC < SYNC_STAGES + 1) begin : g_timing_guard
    $error("bus_arb_seq: clock rate cannot meet the bus timing windows");
  end

  // Input synchronisation
  logic [SYNC_W-1:0] raw_in, sync_out;
  logic              rst_s, sel_s, bsy_s;
  logic [DATA_W-1:0] data_s;

  assign raw_in = {rst_line, sel_line, bsy_line, data_line};

  bus_arb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw_in),
    .dout(sync_out)
  );

  assign rst_s  = sync_out[DATA_W+2];
  assign sel_s  = sync_out[DATA_W+1];
  assign bsy_s  = sync_out[DATA_W];
  assign data_s = sync_out[DATA_W-1:0];

  // Free-bus detection and line stabilisation
  logic free_q;
  logic lines_stable;

  bus_arb_free #(.SETTLE_CYC(SETTLE_CYC)) u_free (
    .clk  (clk),
    .rst  (rst),
    .bsy_s(bsy_s),
    .sel_s(sel_s),
    .free (free_q)
  );

  bus_arb_deskew #(.DATA_W(DATA_W), .DESKEW_CYC(DESKEW_CYC)) u_deskew (
    .clk   (clk),
    .rst   (rst),
    .data_s(data_s),
    .stable(lines_stable)
  );

  // Contention sequencer
  arb_state_e        state_q;
  logic [ARB_W-1:0]  arb_cnt;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] above_mask;
  logic              higher_seen;

  assign above_mask  = {DATA_W{1'b1}} << (int'(id_q) + 1);
  assign higher_seen = |(data_s & above_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ARB_IDLE;
      arb_cnt   <= '0;
      id_q      <= '0;
      bsy_drive <= 1'b0;
      sel_drive <= 1'b0;
      id_drive  <= '0;
      won_pulse <= 1'b0;
    end else begin
      won_pulse <= 1'b0;
      if (rst_s) begin
        state_q   <= ARB_IDLE;
        bsy_drive <= 1'b0;
        sel_drive <= 1'b0;
        id_drive  <= '0;
      end else begin
        unique case (state_q)
          ARB_IDLE: begin
            if (free_q && arb_req) begin
              state_q   <= ARB_CONTEND;
              bsy_drive <= 1'b1;
              id_drive  <= DATA_W'(1) << own_id;
              id_q      <= own_id;
              arb_cnt   <= '0;
            end
          end
          ARB_CONTEND: begin
            if (sel_s) begin
              state_q   <= ARB_IDLE;
              bsy_drive <= 1'b0;
              id_drive  <= '0;
            end else if (arb_cnt != ARB_W'(ARB_CYC)) begin
              arb_cnt <= arb_cnt + 1'b1;
            end else if (lines_stable) begin
              if (!higher_seen) begin
                state_q   <= ARB_OWNED;
                sel_drive <= 1'b1;
                won_pulse <= 1'b1;
              end else begin
                state_q   <= ARB_IDLE;
                bsy_drive <= 1'b0;
                id_drive  <= '0;
              end
            end
          end
          ARB_OWNED: begin
            if (release_req) begin
              state_q   <= ARB_IDLE;
              bsy_drive <= 1'b0;
              sel_drive <= 1'b0;
              id_drive  <= '0;
            end
          end
          default: begin
            state_q   <= ARB_IDLE;
            bsy_drive <= 1'b0;
            sel_drive <= 1'b0;
            id_drive  <= '0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/bus_arb_chk.sv
`timescale 1ns/1ps
module bus_arb_chk
  import bus_arb_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ARB_CYC       = 600,
  parameter int FREE_MAX_CYC  = 200,
  parameter int CLEAR_MAX_CYC = 200
) (
  input logic              clk,
  input logic              rst,
  input logic              rst_s,
  input logic              sel_s,
  input logic              free_q,
  input logic              arb_req,
  input logic              release_req,
  input arb_state_e        state_q,
  input logic              bsy_drive,
  input logic              sel_drive,
  input logic [DATA_W-1:0] id_drive,
  input logic              won_pulse
);

  localparam int AW = $clog2(ARB_CYC + 3);
  localparam int PW = $clog2(FREE_MAX_CYC + 3);
  localparam int KW = $clog2(CLEAR_MAX_CYC + 3);

  logic [AW-1:0] bsy_age;
  logic [PW-1:0] pend_age;
  logic [KW-1:0] clear_age;
  logic          any_drive;
  logic          clear_cause;

  assign any_drive   = bsy_drive || sel_drive || (id_drive != '0);
  assign clear_cause = rst_s || (state_q == ARB_CONTEND && sel_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      bsy_age   <= '0;
      pend_age  <= '0;
      clear_age <= '0;
    end else begin
      if (!bsy_drive)                       bsy_age <= '0;
      else if (bsy_age != AW'(ARB_CYC + 2)) bsy_age <= bsy_age + 1'b1;

      if (free_q && arb_req && !rst_s && state_q == ARB_IDLE) begin
        if (pend_age != PW'(FREE_MAX_CYC + 2)) pend_age <= pend_age + 1'b1;
      end else begin
        pend_age <= '0;
      end

      if (clear_cause && any_drive) begin
        if (clear_age != KW'(CLEAR_MAX_CYC + 2)) clear_age <= clear_age + 1'b1;
      end else begin
        clear_age <= '0;
      end
    end
  end

  AST_SEL_NEEDS_BSY:   assert property (@(posedge clk) disable iff (rst) sel_drive |-> bsy_drive);                // R8
  AST_ID_ONE_HOT:      assert property (@(posedge clk) disable iff (rst) bsy_drive |-> $countones(id_drive) == 1); // R3
  AST_ID_RELEASED:     assert property (@(posedge clk) disable iff (rst) !bsy_drive |-> id_drive == '0);          // R9
  AST_WON_SINGLE:      assert property (@(posedge clk) disable iff (rst) won_pulse |=> !won_pulse);               // R8
  AST_SEL_RISE_WON:    assert property (@(posedge clk) disable iff (rst) $rose(sel_drive) |-> won_pulse);         // R8
  AST_ARB_MIN_WAIT:    assert property (@(posedge clk) disable iff (rst) won_pulse |-> bsy_age > AW'(ARB_CYC));   // R5
  AST_START_WINDOW:    assert property (@(posedge clk) disable iff (rst) pend_age <= PW'(FREE_MAX_CYC));          // R3
  AST_RST_RELEASE:     assert property (@(posedge clk) disable iff (rst) rst_s |=> !any_drive);                   // R11
  AST_CLEAR_WINDOW:    assert property (@(posedge clk) disable iff (rst) clear_age <= KW'(CLEAR_MAX_CYC));        // R11
  AST_FOREIGN_SEL:     assert property (@(posedge clk) disable iff (rst)
                         (state_q == ARB_CONTEND && sel_s && !rst_s) |=> !bsy_drive);                              // R10
  AST_RELEASE_REQ:     assert property (@(posedge clk) disable iff (rst)
                         (state_q == ARB_OWNED && release_req) |=> !any_drive);                                    // R12

endmodule

bind bus_arb_seq bus_arb_chk #(
  .DATA_W       (DATA_W),
  .ARB_CYC      (ARB_CYC),
  .FREE_MAX_CYC (FREE_MAX_CYC),
  .CLEAR_MAX_CYC(CLEAR_MAX_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rst_s      (rst_s),
  .sel_s      (sel_s),
  .free_q     (free_q),
  .arb_req    (arb_req),
  .release_req(release_req),
  .state_q    (state_q),
  .bsy_drive  (bsy_drive),
  .sel_drive  (sel_drive),
  .id_drive   (id_drive),
  .won_pulse  (won_pulse)
);

// File: tb/tb_bus_arb_seq.sv
`timescale 1ns/1ps
module tb_bus_arb_seq;

  localparam int SYNC   = 2;
  localparam int SETTLE = (400 * 250 + 999) / 1000;   // 100
  localparam int ARBW   = (2400 * 250 + 999) / 1000;  // 600
  localparam int DESK   = (45 * 250 + 999) / 1000;    // 12
  localparam int START  = SYNC + SETTLE + 1;
  localparam int DECIDE = ARBW + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       arb_req = 1'b0;
  logic [2:0] own_id = '0;
  logic       release_req = 1'b0;
  logic       comp_bsy = 1'b1, comp_sel = 1'b0, comp_rst = 1'b0;
  logic [7:0] comp_data = '0;
  logic       bsy_drive, sel_drive, won_pulse;
  logic [7:0] id_drive;
  logic       bsy_line, sel_line;
  logic [7:0] data_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  assign bsy_line  = bsy_drive | comp_bsy;
  assign sel_line  = sel_drive | comp_sel;
  assign data_line = id_drive | comp_data;

  bus_arb_seq dut (
    .clk(clk), .rst(rst), .arb_req(arb_req), .own_id(own_id),
    .release_req(release_req), .bsy_line(bsy_line), .sel_line(sel_line),
    .rst_line(comp_rst), .data_line(data_line),
    .bsy_drive(bsy_drive), .sel_drive(sel_drive), .id_drive(id_drive),
    .won_pulse(won_pulse)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Hold the bus busy, then release it and count edges until bsy_drive rises.
  task automatic start_arb(input int id, output int n);
    @(negedge clk); comp_bsy = 1'b1; comp_data = '0;
    repeat (4) @(negedge clk);
    own_id = 3'(id); arb_req = 1'b1; comp_bsy = 1'b0;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!bsy_drive && n < 2000);
  endtask

  task automatic wait_decision(output int m);
    m = 0;
    do begin @(posedge clk); #1; m++; end while (!won_pulse && bsy_drive && m < 2000);
  endtask

  task automatic give_back();
    @(negedge clk); arb_req = 1'b0; release_req = 1'b1;
    @(posedge clk); #1;
    chk(!bsy_drive && !sel_drive && id_drive == 0, "R12 release_req", bsy_drive, 0);
    @(negedge clk); release_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, m;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(!bsy_drive && !sel_drive && !won_pulse && id_drive == 0, "R1 reset state", id_drive, 0);

    // R7 sweep: every own ID against every competitor ID and against none
    for (int i = 0; i < 8; i++) begin
      for (int j = -1; j < 8; j++) begin
        if (j == i) continue;
        start_arb(i, n);
        chk(n == START, "R3 start latency", n, START);
        chk(id_drive == 8'(1 << i), "R3 own ID bit", id_drive, 1 << i);
        @(negedge clk);
        if (j >= 0) begin comp_bsy = 1'b1; comp_data = 8'(1 << j); end
        wait_decision(m);
        chk(m == DECIDE, "R5 decision edge", m, DECIDE);
        if (j < i) begin
          chk(won_pulse && sel_drive && bsy_drive, "R7 win expected", won_pulse, 1);
          @(posedge clk); #1;
          chk(!won_pulse && sel_drive && id_drive == 8'(1 << i), "R8 single pulse, hold", won_pulse, 0);
          @(negedge clk); comp_bsy = 1'b0; comp_data = '0;
          give_back();
        end else begin
          chk(!won_pulse && !bsy_drive && id_drive == 0, "R7 loss expected", bsy_drive, 0);
          @(negedge clk); arb_req = 1'b0; comp_data = '0;
        end
      end
    end

    // R9: lose, keep requesting, contend again at the next free bus
    start_arb(2, n);
    @(negedge clk); comp_bsy = 1'b1; comp_data = 8'h20;
    wait_decision(m);
    chk(!bsy_drive && !won_pulse, "R9 loss releases", bsy_drive, 0);
    @(negedge clk); comp_bsy = 1'b0; comp_data = '0;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!bsy_drive && n < 2000);
    chk(n == START, "R9 re-contend latency", n, START);
    wait_decision(m);
    chk(won_pulse, "R9 re-contend win", won_pulse, 1);
    give_back();

    // R6/R13: a low-bit change late in the wait delays the decision by the deskew count
    start_arb(7, n);
    m = 0;
    do begin
      @(posedge clk); m++;
      if (m == 597) begin @(negedge clk); comp_data = 8'h01; end
      else #1;
    end while (!won_pulse && bsy_drive && m < 2000);
    chk(m == 597 + SYNC + 2 + DESK, "R6 R13 deskew delay", m, 597 + SYNC + 2 + DESK);
    chk(won_pulse, "R7 lower bit ignored", won_pulse, 1);
    @(negedge clk); comp_data = '0;
    give_back();

    // R2: a one-cycle select glitch restarts the free count
    @(negedge clk); comp_bsy = 1'b1;
    repeat (4) @(negedge clk);
    own_id = 3'd4; arb_req = 1'b1; comp_bsy = 1'b0;
    repeat (50) @(negedge clk);
    comp_sel = 1'b1;
    @(negedge clk); comp_sel = 1'b0;
    chk(!bsy_drive, "R2 no early start", bsy_drive, 0);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!bsy_drive && n < 2000);
    chk(n == START, "R2 restarted count", n, START);
    wait_decision(m);
    give_back();

    // R4: free bus without a request
    @(negedge clk); comp_bsy = 1'b1;
    repeat (4) @(negedge clk);
    comp_bsy = 1'b0;
    n = 0;
    for (int k = 0; k < 300; k++) begin
      @(posedge clk); #1;
      if (bsy_drive || id_drive != 0) n++;
    end
    chk(n == 0, "R4 no request no drive", n, 0);

    // R10: foreign select during contention
    start_arb(7, n);
    repeat (300) @(posedge clk);
    @(negedge clk); comp_sel = 1'b1;
    repeat (SYNC) @(posedge clk);
    #1 chk(bsy_drive, "R10 still driving before sync", bsy_drive, 1);
    @(posedge clk); #1;
    chk(!bsy_drive && id_drive == 0, "R10 foreign select release", bsy_drive, 0);
    @(negedge clk); comp_sel = 1'b0; arb_req = 1'b0;

    // R11: bus reset during contention
    start_arb(5, n);
    repeat (100) @(posedge clk);
    @(negedge clk); comp_rst = 1'b1;
    repeat (SYNC + 1) @(posedge clk);
    #1 chk(!bsy_drive && id_drive == 0, "R11 reset in contention", bsy_drive, 0);
    @(negedge clk); comp_rst = 1'b0; arb_req = 1'b0;

    // R11: bus reset while holding, hold reset, then contend after it falls
    start_arb(7, n);
    wait_decision(m);
    chk(sel_drive, "R8 holding before reset", sel_drive, 1);
    @(negedge clk); comp_rst = 1'b1;
    repeat (SYNC) @(posedge clk);
    #1 chk(sel_drive, "R11 held before sync", sel_drive, 1);
    @(posedge clk); #1;
    chk(!bsy_drive && !sel_drive && id_drive == 0, "R11 reset while holding", sel_drive, 0);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk); #1;
      if (bsy_drive || sel_drive) n++;
    end
    chk(n == 0, "R11 stays released", n, 0);
    @(negedge clk); comp_rst = 1'b0;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!bsy_drive && n < 2000);
    chk(n == SYNC + 1, "R11 contend after reset", n, SYNC + 1);
    wait_decision(m);
    give_back();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule